// File: doc/BRIEF.md
# Aligned Multi-Ratio Clock Divider

This block derives two slower clocks from one input clock. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter, one fifth or one sixth. Both banks count the same input rising edges and start from the same point, so any rising edge the two banks share falls on the same input edge.

A stop/run control (`en_ni`, active low) is sampled on the falling edge of the input clock. Counting therefore starts and stops only at a boundary where the clock is low, and no output pulse is ever cut short. While stopped, both banks freeze and hold their levels. Pulling `rst_ni` low clears both banks and forces both outputs low at once, with or without a running clock. The block is used where several related clocks must keep a fixed phase to each other: on a clock tree, for a serializer, or for a multi-rate datapath.

Top module: `clkdiv_aligned`

## Requirements
- R1: Bank A divides by 2 when `sel_a_i` is 0 and by 4 when it is 1. The output period is that many input cycles.
- R2: Bank B divides by 4 for `sel_b_i` = 2'b00, by 6 for 2'b01, and by 5 for both 2'b10 and 2'b11.
- R3: For even ratios the output is high for half the period. For divide-by-5 it is high for 2 input cycles and low for 3. Every high and low time is a whole number of input cycles.
- R4: After reset is released with `en_ni` low, both outputs rise on the same input rising edge. This is the first rising edge after the first falling edge that samples the block as running. Later rising edges common to both banks also coincide.
- R5: `en_ni` is sampled only on the falling edge of `clk_i`. A pulse on `en_ni` that begins and ends inside one clock-high phase has no effect. A change made during the low phase takes effect after the next falling edge.
- R6: While the sampled enable is inactive (`en_ni` high), neither output changes. When the block is re-enabled, each bank resumes from the point where it stopped.
- R7: `rst_ni` low acts at once, without a clock edge. It clears both counters and drives both outputs low, and keeps them low while it stays asserted, whatever `clk_i` and `en_ni` do.
- R8: A change of `sel_a_i` or `sel_b_i` while running does not alter the current output period. The new ratio applies from the next period, which starts after the bank's terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| en_ni | input | 1 | Run control, active low, sampled on the falling edge |
| sel_a_i | input | 1 | Bank A ratio select |
| sel_b_i | input | 2 | Bank B ratio select |
| clk_a_o | output | 1 | Bank A divided clock |
| clk_b_o | output | 1 | Bank B divided clock |

## Verification
The bench measures rise-to-rise periods for every select combination. A wrong decode, or an off-by-one in the wrap, shows up there as a period one cycle long or short. It checks the 2/3 split of divide-by-5 and the simultaneous first rise of both banks after reset. A design that counted from different start states would show the two banks offset by one or more cycles. It places short enable glitches inside the clock-high phase and changes during the low phase. A design that sampled on the rising edge, or reacted to the level, would drop or add counts and leave a shortened pulse. Select changes in mid-period catch a design that switches ratio at once and truncates the running period. A reset asserted in the clock-low phase catches a reset that waits for an edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned RATIO_W = 3;
  typedef logic [RATIO_W-1:0] ratio_t;
  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/clkdiv_run_sync.sv
module clkdiv_run_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic run_o
);
  logic run_q;

  // falling-edge capture: run changes only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= ~en_ni;
  end

  assign run_o = run_q;

  always @(run_q) begin
    if (rst_ni) begin
      p_run_in_low_phase_r5: assert (clk_i == 1'b0)
        else $error("run changed while clock high");
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   adv_i,
  input  ratio_t ratio_i,
  output logic   clk_o
);
  ratio_t cnt_q, n_q, n_eff, half;
  logic   out_q;

  // ratio is re-read only at the start of a period
  always_comb begin
    n_eff = (cnt_q == '0) ? ratio_i : n_q;
    half  = n_eff >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      n_q   <= '0;
      out_q <= 1'b0;
    end else if (adv_i) begin
      n_q   <= n_eff;
      cnt_q <= (cnt_q == n_eff - 1'b1) ? '0 : cnt_q + 1'b1;
      out_q <= (cnt_q < half);
    end
  end

  assign clk_o = out_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < n_eff);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(out_q) && $stable(cnt_q)));

  p_rise_at_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> (cnt_q == ratio_t'(1)));

  p_fall_at_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> ($past(cnt_q) == $past(half)));
endmodule

// File: rtl/clkdiv_aligned.sv
module clkdiv_aligned
  import clkdiv_pkg::*;
#(
  parameter int unsigned A_RATIO_LO = 2,
  parameter int unsigned A_RATIO_HI = 4,
  parameter int unsigned B_RATIO_00 = 4,
  parameter int unsigned B_RATIO_01 = 6,
  parameter int unsigned B_RATIO_1X = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_ni,
  input  logic       sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       clk_a_o,
  output logic       clk_b_o
);
  logic   run;
  ratio_t ratio [NUM_BANKS];
  logic   bank_clk [NUM_BANKS];

  always_comb begin
    ratio[0] = sel_a_i ? ratio_t'(A_RATIO_HI) : ratio_t'(A_RATIO_LO);
    unique case (sel_b_i)
      2'b00:   ratio[1] = ratio_t'(B_RATIO_00);
      2'b01:   ratio[1] = ratio_t'(B_RATIO_01);
      default: ratio[1] = ratio_t'(B_RATIO_1X);
    endcase
  end

  clkdiv_run_sync u_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_ni),
    .run_o (run)
  );

  // shared advance strobe keeps all banks in lockstep
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    clkdiv_bank u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (run),
      .ratio_i(ratio[g]),
      .clk_o  (bank_clk[g])
    );
  end

  assign clk_a_o = bank_clk[0];
  assign clk_b_o = bank_clk[1];
endmodule

// File: tb/clkdiv_aligned_bench.sv
`timescale 1ns/100ps
module clkdiv_aligned_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_ni = 1'b0;
  logic       sel_a_i = 1'b0;
  logic [1:0] sel_b_i = 2'b00;
  logic       clk_a_o, clk_b_o;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  // {sel_a, sel_b[1:0], ratio_a[2:0], ratio_b[2:0]}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 2'b00, 3'd2, 3'd4},
    {1'b1, 2'b01, 3'd4, 3'd6},
    {1'b0, 2'b10, 3'd2, 3'd5},
    {1'b1, 2'b11, 3'd4, 3'd5},
    {1'b1, 2'b00, 3'd4, 3'd4},
    {1'b0, 2'b01, 3'd2, 3'd6}
  };

  clkdiv_aligned u_clkdiv_aligned (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_ni  (en_ni),
    .sel_a_i(sel_a_i),
    .sel_b_i(sel_b_i),
    .clk_a_o(clk_a_o),
    .clk_b_o(clk_b_o)
  );

  always #2.5 clk_i = ~clk_i;

  // reference run flag: enable seen at falling edge (R5)
  logic m_en;
  always @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_en <= 1'b0;
    else         m_en <= ~en_ni;
  end

  int ph_a = 0, ph_b = 0, na = 2, nb = 4;
  logic ea = 1'b0, eb = 1'b0;

  function automatic int dec_a(logic s);
    return s ? 4 : 2;
  endfunction
  function automatic int dec_b(logic [1:0] s);
    if (s == 2'b00) return 4;
    if (s == 2'b01) return 6;
    return 5;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic tick(string req);
    @(posedge clk_i);
    #1;
    cyc++;
    if (!rst_ni) begin
      ph_a = 0; ph_b = 0; ea = 1'b0; eb = 1'b0;
    end else if (m_en) begin
      if (ph_a == 0) na = dec_a(sel_a_i);
      ea = (ph_a < na / 2);
      ph_a = (ph_a == na - 1) ? 0 : ph_a + 1;
      if (ph_b == 0) nb = dec_b(sel_b_i);
      eb = (ph_b < nb / 2);
      ph_b = (ph_b == nb - 1) ? 0 : ph_b + 1;
    end
    check(clk_a_o == ea, req, "bank A level", int'(clk_a_o), int'(ea));
    check(clk_b_o == eb, req, "bank B level", int'(clk_b_o), int'(eb));
  endtask

  task automatic do_reset(logic sa, logic [1:0] sb);
    rst_ni = 1'b0;
    en_ni = 1'b0;
    sel_a_i = sa;
    sel_b_i = sb;
    ph_a = 0; ph_b = 0; ea = 1'b0; eb = 1'b0;
    repeat (3) tick("R7");
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
    n_checks++;
    n_fail++;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1;
    check(clk_a_o == 1'b0 && clk_b_o == 1'b0, "R7", "outputs in reset",
          int'({clk_a_o, clk_b_o}), 0);

    // table walk: period, duty, alignment per select setting
    for (int v = 0; v < 6; v++) begin
      logic pa, pb;
      int   ra, rb;
      do_reset(VEC[v][8], VEC[v][7:6]);
      pa = 1'b0; pb = 1'b0; ra = -1; rb = -1;
      for (int k = 1; k <= 40; k++) begin
        tick("R3");
        if (k == 1)
          check(clk_a_o && clk_b_o, "R4", "first rise aligned",
                int'({clk_a_o, clk_b_o}), 3);
        if (clk_a_o && !pa) begin
          if (ra >= 0) check(cyc - ra == int'(VEC[v][5:3]), "R1", "bank A period",
                             cyc - ra, int'(VEC[v][5:3]));
          ra = cyc;
        end
        if (clk_b_o && !pb) begin
          if (rb >= 0) check(cyc - rb == int'(VEC[v][2:0]), "R2", "bank B period",
                             cyc - rb, int'(VEC[v][2:0]));
          rb = cyc;
        end
        pa = clk_a_o; pb = clk_b_o;
      end
    end

    // R4: common edges of /4 and /6 at ticks 1 and 13
    do_reset(1'b1, 2'b01);
    for (int k = 1; k <= 13; k++) begin
      tick("R4");
      if (k == 12) check(!clk_a_o && !clk_b_o, "R4", "both low before common edge",
                         int'({clk_a_o, clk_b_o}), 0);
      if (k == 13) check(clk_a_o && clk_b_o, "R4", "common rise",
                         int'({clk_a_o, clk_b_o}), 3);
    end

    // R6: freeze and resume
    do_reset(1'b1, 2'b10);
    repeat (3) tick("R6");
    en_ni = 1'b1;
    repeat (6) tick("R6");
    en_ni = 1'b0;
    repeat (12) tick("R6");

    // R5: glitch confined to the clock-high phase is ignored
    #0.5 en_ni = 1'b1;
    #0.5 en_ni = 1'b0;
    repeat (6) tick("R5");
    // R5: change in low phase, effect after next falling edge
    #2 en_ni = 1'b1;
    repeat (4) tick("R5");
    #2 en_ni = 1'b0;
    repeat (8) tick("R5");

    // R8: select change in mid-period
    do_reset(1'b1, 2'b01);
    repeat (2) tick("R8");
    sel_a_i = 1'b0;
    sel_b_i = 2'b10;
    repeat (24) tick("R8");

    // R7: asynchronous reset in the clock-low phase
    do_reset(1'b1, 2'b00);
    repeat (5) tick("R7");
    check(clk_a_o == 1'b1, "R7", "bank A high before reset", int'(clk_a_o), 1);
    #2 rst_ni = 1'b0;
    #0.5;
    check(clk_a_o == 1'b0 && clk_b_o == 1'b0, "R7", "async clear",
          int'({clk_a_o, clk_b_o}), 0);
    ph_a = 0; ph_b = 0; ea = 1'b0; eb = 1'b0;
    repeat (4) tick("R7");
    rst_ni = 1'b1;
    repeat (10) tick("R4");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule